// File: doc/BRIEF.md
# Multiplexed Bus Cycle Decoder

This block sits beside a processor whose address and data share one set of wires. It watches each bus cycle and reports what kind of cycle it is. On the rising edge of the address latch input it takes a snapshot of the cycle type, the bank select, the map enable and the low sixteen bus bits. It then holds a decoded class, a flag that says whether an external device must answer, and a bus-lock flag until the next address latch edge.

General-purpose (GP) writes carry an 8-bit command in the low bus bits. The block acts on these commands. It drives a system initialisation flop and gives one-clock acknowledge pulses for the external event line and for power fail. On a GP read that selects one of the two maintenance registers, the block returns that register's contents during the data phase.

The block also checks the phase timing. The data strobe must follow the address latch by exactly one clock, and data is taken from the bus when data valid is high. When the processor stretches a cycle, the block answers with a resume pulse after a wait that software sets. A prefetch that the processor aborts leaves no trace in the block.

Top module: `bus_cycle_decoder`

## Requirements
- R1: On a clock where `addr_latch` is high and was low on the previous clock, the block captures `ad_bus`, `bank_sel` and `io_map_en` into `cap_addr`, `cap_bank` and `cap_map`. These outputs are visible from the next clock and stay unchanged until the next rising edge of `addr_latch`.
- R2: The cycle type is decoded into `cyc_class`, which changes on the same edge as R1. The encodings are:
  - types 0 and 3 (word and byte write) give 1;
  - types 8 and 9 (instruction and data read) give 2;
  - types 10 and 11 (read-modify-write) give 3;
  - type 12 (prefetch) gives 4;
  - type 13 (interrupt vector read) gives 5;
  - type 5 (GP write) gives 6;
  - type 14 (GP read) gives 7;
  - type 15 (internal) gives 8;
  - every other type gives 0.
  - After reset `cyc_class` is 0.
- R3: `ext_resp` is 1 only when the captured bank is 0 (memory) or 2 (external I/O) and the type is not 15. Banks 1 (system registers) and 3 (internal registers) never need a response.
- R4: `bus_lock` is 1 only for a cycle of type 10.
- R5: `sys_init` is 1 after reset. A GP write (type 5) whose low 8 bits are octal 024 sets it, and one with octal 214 clears it. Any other cycle or code leaves it unchanged.
- R6: A GP write with code octal 100 makes `evt_ack` high for exactly the one clock after capture. Code octal 140 does the same for `pwr_ack`. The two are never high together.
- R7: A GP read (type 14) with code octal 000 makes `gp_rd_en` high and puts `maint_a` on `gp_rd_data`. Code octal 002 does the same with `maint_b`. Any other cycle clears `gp_rd_en` at capture.
- R8: If `data_strobe` is low on the clock after capture, `proto_err` goes high. It is cleared at the next capture.
- R9: When `stretch_req` rises with `wait_cfg` = N (0 to 15), `resume_pulse` is high for exactly one clock, and this happens N+1 clocks after the edge at which the rise was seen.
- R10: During a read-class cycle (class 2, 3, 4 or 5), `data_valid` latches `ad_bus` into `rdata` and pulses `rdata_vld` for one clock. In any other class, `data_valid` has no effect.
- R11: If `cyc_abort` is high in a prefetch cycle, the block raises no strobe error and `data_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_latch | input | 1 | Address latch enable; its rising edge starts a cycle |
| data_strobe | input | 1 | Data strobe, expected one clock after capture |
| cyc_type | input | 4 | Cycle type code |
| bank_sel | input | 2 | Bank select code |
| io_map_en | input | 1 | External I/O map enable |
| ad_bus | input | 16 | Multiplexed address/data bits |
| data_valid | input | 1 | Data valid, latches read data |
| stretch_req | input | 1 | Stretch control from the processor |
| cyc_abort | input | 1 | Cycle abort |
| wait_cfg | input | 4 | Clocks to wait before resuming a stretched cycle |
| maint_a | input | 16 | Maintenance register selected by code 000 |
| maint_b | input | 16 | Maintenance register selected by code 002 |
| cyc_class | output | 4 | Decoded cycle class |
| cap_addr | output | 16 | Captured address bits |
| cap_bank | output | 2 | Captured bank select |
| cap_map | output | 1 | Captured map enable |
| ext_resp | output | 1 | Cycle needs an external response |
| bus_lock | output | 1 | Locked read-modify-write in progress |
| sys_init | output | 1 | System initialisation flop |
| evt_ack | output | 1 | Event acknowledge pulse |
| pwr_ack | output | 1 | Power-fail acknowledge pulse |
| gp_rd_en | output | 1 | GP read data is being returned |
| gp_rd_data | output | 16 | Returned maintenance register |
| rdata | output | 16 | Latched read data |
| rdata_vld | output | 1 | Read data latched this clock |
| proto_err | output | 1 | Missing or late strobe |
| resume_pulse | output | 1 | Continue pulse ending a stretch |

## Verification
A GP write and a stretch request can land on the same edge. An event acknowledge and a zero-wait resume pulse are then due in the same clock. The bench provokes this by raising the address latch with a GP write of code 100 and, on the same clock, raising the stretch request with a wait of zero. It expects both pulses high together on the next sample and both low one clock later. A protocol error and an aborted prefetch also meet in the same clock. Randomly placed aborts on prefetch cycles with a missing strobe must leave `proto_err` low, while the same cycle without an abort must raise it.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int TYPE_W = 4;
  localparam int BANK_W = 2;
  localparam int CODE_W = 8;

  typedef enum logic [3:0] {
    CL_NONE     = 4'd0,
    CL_WRITE    = 4'd1,
    CL_READ     = 4'd2,
    CL_RMW      = 4'd3,
    CL_PREFETCH = 4'd4,
    CL_IACK     = 4'd5,
    CL_GP_WR    = 4'd6,
    CL_GP_RD    = 4'd7,
    CL_INTERNAL = 4'd8
  } cyc_class_e;

  localparam logic [TYPE_W-1:0] T_WR_WORD  = 4'd0;
  localparam logic [TYPE_W-1:0] T_WR_BYTE  = 4'd3;
  localparam logic [TYPE_W-1:0] T_GP_WR    = 4'd5;
  localparam logic [TYPE_W-1:0] T_I_READ   = 4'd8;
  localparam logic [TYPE_W-1:0] T_D_READ   = 4'd9;
  localparam logic [TYPE_W-1:0] T_RMW_LOCK = 4'd10;
  localparam logic [TYPE_W-1:0] T_RMW_FREE = 4'd11;
  localparam logic [TYPE_W-1:0] T_PREFETCH = 4'd12;
  localparam logic [TYPE_W-1:0] T_IACK     = 4'd13;
  localparam logic [TYPE_W-1:0] T_GP_RD    = 4'd14;
  localparam logic [TYPE_W-1:0] T_INTERNAL = 4'd15;

  localparam logic [BANK_W-1:0] BK_MEM  = 2'd0;
  localparam logic [BANK_W-1:0] BK_EXT  = 2'd2;

  localparam logic [CODE_W-1:0] GP_INIT_CLR = 8'o214;
  localparam logic [CODE_W-1:0] GP_INIT_SET = 8'o024;
  localparam logic [CODE_W-1:0] GP_EVT_ACK  = 8'o100;
  localparam logic [CODE_W-1:0] GP_PWR_ACK  = 8'o140;
  localparam logic [CODE_W-1:0] GP_MAINT_A  = 8'o000;
  localparam logic [CODE_W-1:0] GP_MAINT_B  = 8'o002;

  function automatic cyc_class_e classify(input logic [TYPE_W-1:0] t);
    case (t)
      T_WR_WORD, T_WR_BYTE:   return CL_WRITE;
      T_I_READ, T_D_READ:     return CL_READ;
      T_RMW_LOCK, T_RMW_FREE: return CL_RMW;
      T_PREFETCH:             return CL_PREFETCH;
      T_IACK:                 return CL_IACK;
      T_GP_WR:                return CL_GP_WR;
      T_GP_RD:                return CL_GP_RD;
      T_INTERNAL:             return CL_INTERNAL;
      default:                return CL_NONE;
    endcase
  endfunction

  function automatic logic takes_read_data(input cyc_class_e c);
    return (c == CL_READ) || (c == CL_RMW) || (c == CL_PREFETCH) || (c == CL_IACK);
  endfunction
endpackage

// File: rtl/bcd_capture.sv
module bcd_capture
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_latch,
  input  logic [TYPE_W-1:0] cyc_type,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              io_map_en,
  input  logic [ADDR_W-1:0] ad_bus,
  output logic              latch_rise,
  output cyc_class_e        cls_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              map_q,
  output logic              ext_q,
  output logic              lock_q
);
  logic       latch_d;
  cyc_class_e cls_next;

  assign latch_rise = addr_latch & ~latch_d;
  assign cls_next   = classify(cyc_type);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_d <= 1'b0;
      cls_q   <= CL_NONE;
      addr_q  <= '0;
      bank_q  <= '0;
      map_q   <= 1'b0;
      ext_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      latch_d <= addr_latch;
      if (latch_rise) begin
        cls_q  <= cls_next;
        addr_q <= ad_bus;
        bank_q <= bank_sel;
        map_q  <= io_map_en;
        ext_q  <= ((bank_sel == BK_MEM) || (bank_sel == BK_EXT)) &&
                  (cls_next != CL_INTERNAL);
        lock_q <= (cyc_type == T_RMW_LOCK);
      end
    end
  end
endmodule

// File: rtl/bcd_gp_ctrl.sv
module bcd_gp_ctrl
  import bcd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_rise,
  input  logic [TYPE_W-1:0] cyc_type,
  input  logic [CODE_W-1:0] gp_code,
  input  logic [DATA_W-1:0] maint_a,
  input  logic [DATA_W-1:0] maint_b,
  output logic              init_q,
  output logic              evt_ack_q,
  output logic              pwr_ack_q,
  output logic              rd_en_q,
  output logic [DATA_W-1:0] rd_data_q
);
  logic gp_wr, gp_rd;

  assign gp_wr = latch_rise && (cyc_type == T_GP_WR);
  assign gp_rd = latch_rise && (cyc_type == T_GP_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q    <= 1'b1;
      evt_ack_q <= 1'b0;
      pwr_ack_q <= 1'b0;
      rd_en_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      evt_ack_q <= gp_wr && (gp_code == GP_EVT_ACK);
      pwr_ack_q <= gp_wr && (gp_code == GP_PWR_ACK);
      if (gp_wr && (gp_code == GP_INIT_SET)) init_q <= 1'b1;
      else if (gp_wr && (gp_code == GP_INIT_CLR)) init_q <= 1'b0;
      if (latch_rise) begin
        rd_en_q <= gp_rd && ((gp_code == GP_MAINT_A) || (gp_code == GP_MAINT_B));
        if (gp_rd && (gp_code == GP_MAINT_A)) rd_data_q <= maint_a;
        else if (gp_rd && (gp_code == GP_MAINT_B)) rd_data_q <= maint_b;
      end
    end
  end
endmodule

// File: rtl/bcd_stretch.sv
module bcd_stretch #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stretch_req,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              resume_q
);
  logic              req_d;
  logic [WAIT_W-1:0] cnt;
  logic              req_rise;

  assign req_rise = stretch_req & ~req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      cnt      <= '0;
      resume_q <= 1'b0;
    end else begin
      req_d    <= stretch_req;
      resume_q <= 1'b0;
      if (req_rise) begin
        cnt <= wait_cfg;
        if (wait_cfg == '0) resume_q <= 1'b1;
      end else if (cnt != '0) begin
        cnt <= cnt - WAIT_W'(1);
        if (cnt == WAIT_W'(1)) resume_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_phase_mon.sv
module bcd_phase_mon
  import bcd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_rise,
  input  cyc_class_e        cls_q,
  input  logic              data_strobe,
  input  logic              cyc_abort,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] ad_bus,
  output logic              err_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvld_q
);
  logic pend;
  logic abort_seen;
  logic dropped;

  assign dropped = (cls_q == CL_PREFETCH) && (cyc_abort || abort_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      abort_seen <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      rvld_q     <= 1'b0;
    end else begin
      rvld_q <= 1'b0;
      if (latch_rise) begin
        pend       <= 1'b1;
        abort_seen <= 1'b0;
        err_q      <= 1'b0;
      end else begin
        pend <= 1'b0;
        if (cyc_abort) abort_seen <= 1'b1;
        if (pend && !data_strobe && !dropped) err_q <= 1'b1;
        if (data_valid && takes_read_data(cls_q) && !dropped) begin
          rdata_q <= ad_bus;
          rvld_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_latch,
  input  logic              data_strobe,
  input  logic [3:0]        cyc_type,
  input  logic [1:0]        bank_sel,
  input  logic              io_map_en,
  input  logic [ADDR_W-1:0] ad_bus,
  input  logic              data_valid,
  input  logic              stretch_req,
  input  logic              cyc_abort,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic [ADDR_W-1:0] maint_a,
  input  logic [ADDR_W-1:0] maint_b,
  output logic [3:0]        cyc_class,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [1:0]        cap_bank,
  output logic              cap_map,
  output logic              ext_resp,
  output logic              bus_lock,
  output logic              sys_init,
  output logic              evt_ack,
  output logic              pwr_ack,
  output logic              gp_rd_en,
  output logic [ADDR_W-1:0] gp_rd_data,
  output logic [ADDR_W-1:0] rdata,
  output logic              rdata_vld,
  output logic              proto_err,
  output logic              resume_pulse
);
  logic       latch_rise;
  cyc_class_e cls_q;

  bcd_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .addr_latch(addr_latch), .cyc_type(cyc_type),
    .bank_sel(bank_sel), .io_map_en(io_map_en), .ad_bus(ad_bus),
    .latch_rise(latch_rise), .cls_q(cls_q), .addr_q(cap_addr),
    .bank_q(cap_bank), .map_q(cap_map), .ext_q(ext_resp), .lock_q(bus_lock)
  );

  bcd_gp_ctrl #(.DATA_W(ADDR_W)) u_gp (
    .clk(clk), .rst(rst), .latch_rise(latch_rise), .cyc_type(cyc_type),
    .gp_code(ad_bus[CODE_W-1:0]), .maint_a(maint_a), .maint_b(maint_b),
    .init_q(sys_init), .evt_ack_q(evt_ack), .pwr_ack_q(pwr_ack),
    .rd_en_q(gp_rd_en), .rd_data_q(gp_rd_data)
  );

  bcd_phase_mon #(.DATA_W(ADDR_W)) u_mon (
    .clk(clk), .rst(rst), .latch_rise(latch_rise), .cls_q(cls_q),
    .data_strobe(data_strobe), .cyc_abort(cyc_abort), .data_valid(data_valid),
    .ad_bus(ad_bus), .err_q(proto_err), .rdata_q(rdata), .rvld_q(rdata_vld)
  );

  bcd_stretch #(.WAIT_W(WAIT_W)) u_str (
    .clk(clk), .rst(rst), .stretch_req(stretch_req), .wait_cfg(wait_cfg),
    .resume_q(resume_pulse)
  );

  assign cyc_class = cls_q;
endmodule

// File: rtl/bus_cycle_decoder_checker.sv
module bus_cycle_decoder_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_latch,
  input logic [3:0]        cyc_type,
  input logic              stretch_req,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic [3:0]        cyc_class,
  input logic              ext_resp,
  input logic              sys_init,
  input logic              evt_ack,
  input logic              pwr_ack,
  input logic              resume_pulse
);
  a_r6_evt_one_clock: assert property (@(posedge clk) disable iff (rst)
    evt_ack |=> !evt_ack);

  a_r6_pwr_one_clock: assert property (@(posedge clk) disable iff (rst)
    pwr_ack |=> !pwr_ack);

  a_r6_acks_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(evt_ack && pwr_ack));

  a_r5_init_only_on_gp_write: assert property (@(posedge clk) disable iff (rst)
    !($rose(addr_latch) && cyc_type == 4'd5) |=> $stable(sys_init));

  a_r9_zero_wait_resume: assert property (@(posedge clk) disable iff (rst)
    ($rose(stretch_req) && wait_cfg == '0) |=> resume_pulse);

  a_r3_internal_no_response: assert property (@(posedge clk) disable iff (rst)
    (cyc_class == 4'd8) |-> !ext_resp);
endmodule

bind bus_cycle_decoder bus_cycle_decoder_checker #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .addr_latch(addr_latch), .cyc_type(cyc_type),
  .stretch_req(stretch_req), .wait_cfg(wait_cfg), .cyc_class(cyc_class),
  .ext_resp(ext_resp), .sys_init(sys_init), .evt_ack(evt_ack),
  .pwr_ack(pwr_ack), .resume_pulse(resume_pulse)
);

// File: tb/bus_cycle_decoder_bench.sv
module bus_cycle_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_latch = 1'b0, data_strobe = 1'b0, io_map_en = 1'b0;
  logic [3:0]  cyc_type = '0;
  logic [1:0]  bank_sel = '0;
  logic [15:0] ad_bus = '0;
  logic        data_valid = 1'b0, stretch_req = 1'b0, cyc_abort = 1'b0;
  logic [3:0]  wait_cfg = '0;
  logic [15:0] maint_a = 16'h1357, maint_b = 16'hA0B1;
  logic [3:0]  cyc_class;
  logic [15:0] cap_addr, gp_rd_data, rdata;
  logic [1:0]  cap_bank;
  logic        cap_map, ext_resp, bus_lock, sys_init, evt_ack, pwr_ack;
  logic        gp_rd_en, rdata_vld, proto_err, resume_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic init_m = 1'b1;

  always #2 clk = ~clk;

  bus_cycle_decoder u_bus_cycle_decoder (
    .clk(clk), .rst(rst), .addr_latch(addr_latch), .data_strobe(data_strobe),
    .cyc_type(cyc_type), .bank_sel(bank_sel), .io_map_en(io_map_en),
    .ad_bus(ad_bus), .data_valid(data_valid), .stretch_req(stretch_req),
    .cyc_abort(cyc_abort), .wait_cfg(wait_cfg), .maint_a(maint_a),
    .maint_b(maint_b), .cyc_class(cyc_class), .cap_addr(cap_addr),
    .cap_bank(cap_bank), .cap_map(cap_map), .ext_resp(ext_resp),
    .bus_lock(bus_lock), .sys_init(sys_init), .evt_ack(evt_ack),
    .pwr_ack(pwr_ack), .gp_rd_en(gp_rd_en), .gp_rd_data(gp_rd_data),
    .rdata(rdata), .rdata_vld(rdata_vld), .proto_err(proto_err),
    .resume_pulse(resume_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cls(input logic [3:0] t);
    case (t)
      4'd0, 4'd3:   return 4'd1;
      4'd8, 4'd9:   return 4'd2;
      4'd10, 4'd11: return 4'd3;
      4'd12:        return 4'd4;
      4'd13:        return 4'd5;
      4'd5:         return 4'd6;
      4'd14:        return 4'd7;
      4'd15:        return 4'd8;
      default:      return 4'd0;
    endcase
  endfunction

  function automatic logic exp_read(input logic [3:0] t);
    logic [3:0] c = exp_cls(t);
    return (c >= 4'd2) && (c <= 4'd5);
  endfunction

  task automatic do_cycle(input logic [3:0] t, input logic [1:0] b, input logic m,
                          input logic [15:0] d, input bit strb_ok, input bit abrt,
                          input bit give_dv, input logic [15:0] rd);
    bit drop;
    drop = (t == 4'd12) && abrt;
    @(negedge clk);
    addr_latch = 1'b1; cyc_type = t; bank_sel = b; io_map_en = m; ad_bus = d;
    @(negedge clk);
    chk("R1 addr", cap_addr, d);
    chk("R1 bank", cap_bank, b);
    chk("R1 map", cap_map, m);
    chk("R2 class", cyc_class, exp_cls(t));
    chk("R3 ext", ext_resp, ((b == 2'd0) || (b == 2'd2)) && (t != 4'd15));
    chk("R4 lock", bus_lock, t == 4'd10);
    chk("R8 cleared", proto_err, 1'b0);
    chk("R6 evt", evt_ack, (t == 4'd5) && (d[7:0] == 8'o100));
    chk("R6 pwr", pwr_ack, (t == 4'd5) && (d[7:0] == 8'o140));
    if (t == 4'd5 && d[7:0] == 8'o024) init_m = 1'b1;
    if (t == 4'd5 && d[7:0] == 8'o214) init_m = 1'b0;
    chk("R5 init", sys_init, init_m);
    chk("R7 en", gp_rd_en, (t == 4'd14) && ((d[7:0] == 8'o000) || (d[7:0] == 8'o002)));
    if (t == 4'd14 && d[7:0] == 8'o000) chk("R7 data a", gp_rd_data, maint_a);
    if (t == 4'd14 && d[7:0] == 8'o002) chk("R7 data b", gp_rd_data, maint_b);
    addr_latch = 1'b0; data_strobe = strb_ok; cyc_abort = abrt; ad_bus = ~d;
    @(negedge clk);
    chk(drop ? "R11 no err" : "R8 err", proto_err, !strb_ok && !drop);
    chk("R6 evt low", evt_ack, 1'b0);
    chk("R6 pwr low", pwr_ack, 1'b0);
    data_strobe = 1'b0;
    if (give_dv) begin data_valid = 1'b1; ad_bus = rd; end
    @(negedge clk);
    chk(drop ? "R11 no data" : "R10 vld", rdata_vld, give_dv && exp_read(t) && !drop);
    if (give_dv && exp_read(t) && !drop) chk("R10 data", rdata, rd);
    chk("R1 held", cap_addr, d);
    data_valid = 1'b0; cyc_abort = 1'b0;
  endtask

  task automatic do_stretch(input logic [3:0] n);
    @(negedge clk);
    stretch_req = 1'b1; wait_cfg = n;
    for (int i = 1; i <= int'(n) + 2; i++) begin
      @(negedge clk);
      chk("R9 resume", resume_pulse, i == int'(n) + 1);
    end
    stretch_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset init", sys_init, 1'b1);
    chk("R2 reset class", cyc_class, 4'd0);
    chk("R8 reset err", proto_err, 1'b0);
    chk("R9 reset resume", resume_pulse, 1'b0);
    chk("R6 reset acks", {evt_ack, pwr_ack}, 2'b00);

    do_cycle(4'd5, 2'd1, 1'b0, 16'h008C, 1, 0, 0, 16'h0);
    do_cycle(4'd5, 2'd1, 1'b0, 16'h0055, 1, 0, 0, 16'h0);
    do_cycle(4'd0, 2'd0, 1'b1, 16'h0014, 1, 0, 1, 16'hBEEF);
    do_cycle(4'd5, 2'd1, 1'b0, 16'h0014, 1, 0, 0, 16'h0);
    do_cycle(4'd5, 2'd1, 1'b0, 16'h0040, 1, 0, 0, 16'h0);
    do_cycle(4'd5, 2'd1, 1'b0, 16'h0060, 1, 0, 0, 16'h0);
    do_cycle(4'd14, 2'd3, 1'b0, 16'h0000, 1, 0, 0, 16'h0);
    do_cycle(4'd14, 2'd3, 1'b0, 16'h0002, 1, 0, 0, 16'h0);
    do_cycle(4'd14, 2'd3, 1'b0, 16'h0004, 1, 0, 0, 16'h0);
    do_cycle(4'd12, 2'd0, 1'b0, 16'h1000, 0, 1, 1, 16'h7777);
    do_cycle(4'd12, 2'd0, 1'b0, 16'h1002, 0, 0, 1, 16'h6666);
    do_cycle(4'd9, 2'd2, 1'b1, 16'hFFFE, 1, 0, 1, 16'h4321);
    do_cycle(4'd10, 2'd0, 1'b0, 16'h0200, 1, 0, 1, 16'h00AA);
    do_cycle(4'd15, 2'd0, 1'b0, 16'h0000, 1, 0, 1, 16'h0BAD);

    do_stretch(4'd0);
    do_stretch(4'd1);
    do_stretch(4'd7);
    do_stretch(4'd15);

    // Same-cycle case: event acknowledge (R6) and zero-wait resume (R9)
    @(negedge clk);
    addr_latch = 1'b1; cyc_type = 4'd5; bank_sel = 2'd1; ad_bus = 16'h0040;
    stretch_req = 1'b1; wait_cfg = 4'd0;
    @(negedge clk);
    chk("R6 evt with resume", evt_ack, 1'b1);
    chk("R9 resume with evt", resume_pulse, 1'b1);
    addr_latch = 1'b0; data_strobe = 1'b1;
    @(negedge clk);
    chk("R6 evt ends", evt_ack, 1'b0);
    chk("R9 resume ends", resume_pulse, 1'b0);
    data_strobe = 1'b0; stretch_req = 1'b0;

    for (int k = 0; k < 300; k++) begin
      d = 16'($urandom);
      case ($urandom % 4)
        0: d[7:0] = 8'o024;
        1: d[7:0] = 8'o214;
        2: d[7:0] = ($urandom % 2) ? 8'o100 : 8'o140;
        default: d[7:0] = ($urandom % 2) ? 8'o000 : 8'o002;
      endcase
      maint_a = 16'($urandom);
      maint_b = 16'($urandom);
      do_cycle(4'($urandom), 2'($urandom), 1'($urandom), d,
               ($urandom % 6) != 0, ($urandom % 4) == 0, ($urandom % 5) != 0,
               16'($urandom));
      if (k % 50 == 0) do_stretch(4'($urandom));
    end
    finish_run();
  end
endmodule